// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers thirteen level-sensitive interrupt sources, numbered 1 to 13, into a pending register that is sampled on every clock. A mask register hides selected sources. Among the sources that are still active, an arbiter picks one and drives an interrupt level of 0 to 7 and an 8-bit vector towards the processor. Each source has an 8-bit control byte. The control byte holds a 5-bit arbitration key. Bits [4:2] of that key are the level sent to the processor. Bit 7 selects a fixed vector instead of a programmed one.

Software reaches the control bytes, the mask, two vector registers and a read-only view of the pending bits through a simple synchronous write port and a combinational read port. In the usual wiring, two timers drive sources 9 and 10 and two serial ports drive sources 12 and 13. The arbitration outputs are combinational from the stored state, so they follow a register write or a pending update without further delay.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Pending bit i takes the value of source input i (irq_src bit i-1) at each clock edge. It reads back at offset 0x3A in bit i, with bits 0, 14 and 15 read as zero. Writes to 0x3A are ignored.
- R2: A one in mask bit i (offset 0x36, 16 bits) masks source i. Only sources that are pending and unmasked take part in arbitration.
- R3: The winner is the active source whose control byte has the largest value in bits [4:0].
- R4: cpu_level equals bits [4:2] of the winner's control byte. With no active source, cpu_level is 0 and cpu_vector is 0.
- R5: When several active sources share the largest bits [4:0], the lowest-numbered one wins.
- R6: The control byte of source i sits at offset 0x13+i (0x14 to 0x20). The software vector register is at 0x42 and the serial vector register at 0x44, both 8 bits. Unmapped offsets read as zero.
- R7: If bit 7 of the winner's control byte is set, cpu_vector is 24 plus cpu_level.
- R8: If bit 7 is clear, cpu_vector is the software vector register for sources 1 to 8 and the serial vector register for sources 12 and 13. For sources 9 to 11 it is 0x0F.
- R9: After reset the mask reads 0xFFFF, the pending bits and control bytes are 0, and both vector registers read 0x0F.
- R10: A register write changes cpu_level and cpu_vector from the clock edge that performs the write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 13 | Source levels; bit i-1 is source i |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| cpu_level | output | 3 | Interrupt level to the processor |
| cpu_vector | output | 8 | Interrupt vector to the processor |

## Verification
Arbitration is tried with everything masked, with a single unmasked source, and with two active sources of different keys. It is also tried with two sources whose keys are equal, where only one of them has bit 7 set. The resulting vector then shows which of the two won, so a tie-break towards the higher-numbered source is told apart from a correct one. Sources from each vector group (1–8, 9–11, 12–13) are made to win alone, which separates the three vector choices. Dropping a source input and writing to the pending offset show that the pending bits follow the inputs and not software.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 13,
  parameter int AW   = 8,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSRC-1:0] irq_src,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [2:0]    cpu_level,
  output logic [7:0]    cpu_vector
);
  localparam logic [AW-1:0] CTL_BASE = AW'(8'h14);
  localparam logic [AW-1:0] MASK_OFS = AW'(8'h36);
  localparam logic [AW-1:0] PEND_OFS = AW'(8'h3A);
  localparam logic [AW-1:0] SWV_OFS  = AW'(8'h42);
  localparam logic [AW-1:0] SERV_OFS = AW'(8'h44);
  localparam int SW_LAST   = 8;
  localparam int SER_FIRST = NSRC - 1;
  localparam int WIDX      = $clog2(NSRC + 1);

  logic [7:0]      ctl [1:NSRC];
  logic [NSRC:1]   pend;
  logic [DW-1:0]   mask;
  logic [7:0]      sw_vec, ser_vec;
  logic [NSRC:1]   active;

  assign active = pend & ~mask[NSRC:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 1; i <= NSRC; i++) ctl[i] <= '0;
      pend    <= '0;
      mask    <= '1;
      sw_vec  <= 8'h0F;
      ser_vec <= 8'h0F;
    end else begin
      pend <= irq_src;
      if (wr_en) begin
        for (int i = 1; i <= NSRC; i++)
          if (addr == CTL_BASE + AW'(i - 1)) ctl[i] <= wdata[7:0];
        if (addr == MASK_OFS) mask    <= wdata;
        if (addr == SWV_OFS)  sw_vec  <= wdata[7:0];
        if (addr == SERV_OFS) ser_vec <= wdata[7:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 1; i <= NSRC; i++)
      if (addr == CTL_BASE + AW'(i - 1)) rdata = DW'(ctl[i]);
    if (addr == MASK_OFS) rdata = mask;
    if (addr == PEND_OFS) rdata = DW'({pend, 1'b0});
    if (addr == SWV_OFS)  rdata = DW'(sw_vec);
    if (addr == SERV_OFS) rdata = DW'(ser_vec);
  end

  logic            found;
  logic [4:0]      best;
  logic [WIDX-1:0] win;
  logic [7:0]      win_ctl;

  always_comb begin
    found   = 1'b0;
    best    = '0;
    win     = '0;
    win_ctl = '0;
    for (int i = 1; i <= NSRC; i++)
      if (active[i] && (!found || ctl[i][4:0] > best)) begin
        found   = 1'b1;
        best    = ctl[i][4:0];
        win     = WIDX'(i);
        win_ctl = ctl[i];
      end
  end

  assign cpu_level = found ? win_ctl[4:2] : 3'd0;

  always_comb begin
    if (!found)                          cpu_vector = 8'h00;
    else if (win_ctl[7])                 cpu_vector = 8'd24 + {5'd0, win_ctl[4:2]};
    else if (win <= WIDX'(SW_LAST))      cpu_vector = sw_vec;
    else if (win >= WIDX'(SER_FIRST))    cpu_vector = ser_vec;
    else                                 cpu_vector = 8'h0F;
  end

  p_pend_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pend == $past(irq_src));

  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_level != 3'd0 |-> (pend & ~mask[NSRC:1]) != '0);

  p_idle_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~mask[NSRC:1]) == '0 |-> cpu_level == 3'd0 && cpu_vector == 8'h00);

  p_win_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> pend[win] && !mask[win]);

  p_mask_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == MASK_OFS |=> mask == $past(wdata));

  p_reset_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> mask == '1 && pend == '0);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] irq_src = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  cpu_level;
  logic [7:0]  cpu_vector;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .cpu_level(cpu_level), .cpu_vector(cpu_vector)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [15:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic set_src(input logic [12:0] s);
    @(negedge clk);
    irq_src = s;
    @(negedge clk);
  endtask

  task automatic out_check(input string req, input logic [2:0] lvl, input logic [7:0] vec);
    check({req, " level"}, {13'd0, cpu_level}, {13'd0, lvl});
    check({req, " vector"}, {8'd0, cpu_vector}, {8'd0, vec});
  endtask

  task automatic t_reset;
    out_check("R9", 3'd0, 8'h00);
    rd_check("R9 mask", 8'h36, 16'hFFFF);
    rd_check("R9 pend", 8'h3A, 16'h0000);
    rd_check("R9 swvec", 8'h42, 16'h000F);
    rd_check("R9 servec", 8'h44, 16'h000F);
    rd_check("R9 ctl", 8'h18, 16'h0000);
  endtask

  task automatic t_all_masked;
    set_src(13'h1FFF);
    rd_check("R1 pend", 8'h3A, 16'h3FFE);
    out_check("R2 masked", 3'd0, 8'h00);
  endtask

  task automatic t_basic_arb;
    wr(8'h14, 16'h0008);
    wr(8'h18, 16'h001D);
    wr(8'h42, 16'h0040);
    wr(8'h36, 16'hFFDD);
    out_check("R3 R10 src5 wins", 3'd7, 8'h40);
    wr(8'h36, 16'hFFFD);
    out_check("R4 R8 src1 alone", 3'd2, 8'h40);
  endtask

  task automatic t_tie;
    wr(8'h16, 16'h009D);
    wr(8'h36, 16'hFFD5);
    out_check("R5 R7 tie to src3", 3'd7, 8'd31);
  endtask

  task automatic t_groups;
    wr(8'h1F, 16'h0014);
    wr(8'h44, 16'h0050);
    wr(8'h36, 16'hEFFF);
    out_check("R8 src12", 3'd5, 8'h50);
    wr(8'h1D, 16'h000C);
    wr(8'h36, 16'hFBFF);
    out_check("R8 src10", 3'd3, 8'h0F);
  endtask

  task automatic t_regs;
    wr(8'h3A, 16'h0000);
    rd_check("R1 pend write ignored", 8'h3A, 16'h3FFE);
    rd_check("R6 ctl3 readback", 8'h16, 16'h009D);
    rd_check("R6 ctl13 offset", 8'h20, 16'h0000);
    rd_check("R6 unmapped", 8'h50, 16'h0000);
    rd_check("R6 mask readback", 8'h36, 16'hFBFF);
  endtask

  task automatic t_drop;
    set_src(13'h1DFF);
    out_check("R1 R4 src10 dropped", 3'd0, 8'h00);
    rd_check("R1 pend after drop", 8'h3A, 16'h3BFE);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_all_masked;
        t_basic_arb;
        t_tie;
        t_groups;
        t_regs;
        t_drop;
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule